// File: doc/BRIEF.md
# Cyclic Read-Only ID Transmitter

This block is the digital core of a transmit-only identification tag. Once power-on reset is released it walks an address counter through a fixed 128-bit identifier, one bit per bit period, and turns each bit into a modulator drive level through one of four line codes. When the last bit has gone out it returns to the first bit and carries on. Nothing travels from the reader to the tag, so the block has no command input and no write path. The identifier is fixed when the block is built.

The only clock is the one recovered from the carrier. Its period is the time unit for the bit timer and for the subcarriers. A rate select sets how many clocks one bit lasts. A code select picks Manchester, biphase, frequency-shift or phase-shift coding. The single output drives the load modulator switch. Both selects are meant to be strapped, so they change only while reset is held.

Top module: `cyclic_id_tx`

## Requirements
- R1: While reset is asserted, and on the first sample after it is asserted, the modulator output is 0. After release, the output in the clock after bit position n reflects position n. Position 0 is the first clock edge after release, and it is the first clock of identifier bit 0.
- R2: Identifier bit k (bit k of the ID_PATTERN parameter) is sent as the k-th bit of every pass. The address's low three bits select one of 8 rows and its upper four bits select one of 16 columns. The address goes up by one at the end of each bit period.
- R3: After address 127 the address returns to 0, and the second pass is identical to the first.
- R4: With rate_sel = 0 a bit lasts 32 clocks. With rate_sel = 1 it lasts 64 clocks.
- R5: With code_sel = 0 (Manchester) the output equals the bit during the first half of the bit period and its inverse during the second half.
- R6: With code_sel = 1 (biphase) an internal level, cleared by reset, inverts at the start of every bit, and inverts once more at the middle of a bit whose value is 0. The output is that level.
- R7: With code_sel = 2 (FSK) the output is a square wave that restarts at the start of each bit. For a 1 it has period 8 (4 clocks high, then 4 low). For a 0 it has period 10 (5 high, then 5 low).
- R8: With code_sel = 3 (PSK) the output toggles on every clock inside a bit. At a bit boundary it toggles when the new bit equals the previous bit, and it holds its level when the bit changes. Equivalently, at position n it equals (n mod 2) XOR bit XOR identifier bit 0.
- R9: A reset asserted in the middle of a transmission restarts the stream from address 0, bit phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock recovered from the carrier |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| rate_sel | input | 1 | Bit period select: 0 = 32 clocks, 1 = 64 clocks |
| code_sel | input | 2 | Line code: 0 Manchester, 1 biphase, 2 FSK, 3 PSK |
| mod_out | output | 1 | Load modulator drive level |

## Verification
The assertions assume that rate_sel and code_sel stay constant while reset is released. For example, they assume that a bit which started at one length never finishes at another, and that the Manchester, biphase and PSK edge rules are never judged against an output produced under another code. The bench changes both selects only while reset is held, and runs each code and rate from a fresh release. The mid-stream reset test likewise keeps its selects fixed across the reset.

// File: rtl/cidt_pkg.sv
`timescale 1ns/1ps
package cidt_pkg;
   typedef enum logic [1:0] {
      LC_MANCH   = 2'd0,
      LC_BIPHASE = 2'd1,
      LC_FSK     = 2'd2,
      LC_PSK     = 2'd3
   } line_code_e;
endpackage

// File: rtl/cidt_bit_timer.sv
`timescale 1ns/1ps
module cidt_bit_timer #(
   parameter int FAST_DIV = 32,
   parameter int SLOW_DIV = 64,
   parameter int ADDR_W   = 7,
   parameter int CNT_W    = $clog2(SLOW_DIV)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rate_sel,
   output logic [CNT_W-1:0]  phase,
   output logic [ADDR_W-1:0] addr,
   output logic              at_start,
   output logic              at_mid,
   output logic              late_half,
   output logic              bit_end
);
   localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_DIV - 1);
   localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_DIV - 1);
   localparam logic [CNT_W-1:0] FAST_HALF = CNT_W'(FAST_DIV / 2);
   localparam logic [CNT_W-1:0] SLOW_HALF = CNT_W'(SLOW_DIV / 2);

   initial begin
      assert (FAST_DIV >= 4 && FAST_DIV % 2 == 0)
         else $error("FAST_DIV must be even and at least 4");
      assert (SLOW_DIV >= FAST_DIV && SLOW_DIV % 2 == 0)
         else $error("SLOW_DIV must be even and not below FAST_DIV");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  last_sel;
   logic [CNT_W-1:0]  half_sel;

   assign last_sel  = rate_sel ? SLOW_LAST : FAST_LAST;
   assign half_sel  = rate_sel ? SLOW_HALF : FAST_HALF;
   assign bit_end   = (cnt_q >= last_sel);
   assign at_start  = (cnt_q == '0);
   assign at_mid    = (cnt_q == half_sel);
   assign late_half = (cnt_q >= half_sel);
   assign phase     = cnt_q;
   assign addr      = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         addr_q <= '0;
      end else if (bit_end) begin
         cnt_q  <= '0;
         addr_q <= addr_q + 1'b1;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/cidt_id_rom.sv
`timescale 1ns/1ps
module cidt_id_rom #(
   parameter int                     ROWS    = 8,
   parameter int                     COLS    = 16,
   parameter int                     ADDR_W  = $clog2(ROWS * COLS),
   parameter logic [ROWS*COLS-1:0]   CONTENT = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              bit_o
);
   localparam int ROW_W = $clog2(ROWS);
   localparam int COL_W = ADDR_W - ROW_W;

   initial begin
      assert (ROWS >= 2 && (1 << ROW_W) == ROWS)
         else $error("ROWS must be a power of two");
      assert (COL_W >= 1 && (1 << COL_W) == COLS)
         else $error("COLS must be a power of two");
   end

   logic [ROWS-1:0] row_oh;
   logic [COLS-1:0] col_oh;
   logic [COLS-1:0] col_line;

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign row_oh[r] = (addr[ROW_W-1:0] == ROW_W'(r));
   end

   for (genvar c = 0; c < COLS; c++) begin : g_col
      assign col_oh[c]   = (addr[ADDR_W-1:ROW_W] == COL_W'(c));
      assign col_line[c] = |(CONTENT[c*ROWS +: ROWS] & row_oh);
   end

   assign bit_o = |(col_line & col_oh);
endmodule

// File: rtl/cidt_line_encoder.sv
`timescale 1ns/1ps
module cidt_line_encoder
   import cidt_pkg::*;
#(
   parameter int FSK_ONE_DIV  = 8,
   parameter int FSK_ZERO_DIV = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  line_code_e code,
   input  logic       data_bit,
   input  logic       at_start,
   input  logic       at_mid,
   input  logic       late_half,
   input  logic       bit_end,
   output logic       mod_o
);
   localparam int FSK_MAX = (FSK_ONE_DIV > FSK_ZERO_DIV) ? FSK_ONE_DIV : FSK_ZERO_DIV;
   localparam int FC_W    = $clog2(FSK_MAX);
   localparam logic [FC_W-1:0] ONE_LAST  = FC_W'(FSK_ONE_DIV - 1);
   localparam logic [FC_W-1:0] ZERO_LAST = FC_W'(FSK_ZERO_DIV - 1);
   localparam logic [FC_W-1:0] ONE_HALF  = FC_W'(FSK_ONE_DIV / 2);
   localparam logic [FC_W-1:0] ZERO_HALF = FC_W'(FSK_ZERO_DIV / 2);

   initial begin
      assert (FSK_ONE_DIV >= 2 && FSK_ONE_DIV % 2 == 0)
         else $error("FSK_ONE_DIV must be even and at least 2");
      assert (FSK_ZERO_DIV >= 2 && FSK_ZERO_DIV % 2 == 0)
         else $error("FSK_ZERO_DIV must be even and at least 2");
   end

   // biphase level
   logic bp_q, bp_next;
   assign bp_next = bp_q ^ at_start ^ (at_mid & ~data_bit);

   // FSK subcarrier divider, restarted at each bit start
   logic [FC_W-1:0] fc_q;
   logic [FC_W-1:0] fc_last, fc_half;
   logic            fsk_lvl;
   assign fc_last = data_bit ? ONE_LAST : ZERO_LAST;
   assign fc_half = data_bit ? ONE_HALF : ZERO_HALF;
   assign fsk_lvl = (fc_q < fc_half);

   // PSK: half-rate carrier with accumulated inversion on bit changes
   logic tog_q, prev_q, primed_q, inv_q, inv_now, psk_lvl;
   assign inv_now = inv_q ^ (primed_q & (data_bit ^ prev_q));
   assign psk_lvl = tog_q ^ inv_now;

   logic mod_next, mod_q;
   always_comb begin
      unique case (code)
         LC_MANCH:   mod_next = data_bit ^ late_half;
         LC_BIPHASE: mod_next = bp_next;
         LC_FSK:     mod_next = fsk_lvl;
         LC_PSK:     mod_next = psk_lvl;
         default:    mod_next = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bp_q     <= 1'b0;
         fc_q     <= '0;
         tog_q    <= 1'b0;
         prev_q   <= 1'b0;
         primed_q <= 1'b0;
         inv_q    <= 1'b0;
         mod_q    <= 1'b0;
      end else begin
         bp_q     <= bp_next;
         fc_q     <= (bit_end || fc_q >= fc_last) ? '0 : fc_q + 1'b1;
         tog_q    <= ~tog_q;
         prev_q   <= data_bit;
         primed_q <= 1'b1;
         inv_q    <= inv_now;
         mod_q    <= mod_next;
      end
   end

   assign mod_o = mod_q;
endmodule

// File: rtl/cyclic_id_tx.sv
`timescale 1ns/1ps
module cyclic_id_tx
   import cidt_pkg::*;
#(
   parameter int                          ID_ROWS      = 8,
   parameter int                          ID_COLS      = 16,
   parameter logic [ID_ROWS*ID_COLS-1:0]  ID_PATTERN   = 128'hA5C3_0F96_E17B_4D28_3C5A_9F01_7E6B_D248,
   parameter int                          FAST_DIV     = 32,
   parameter int                          SLOW_DIV     = 64,
   parameter int                          FSK_ONE_DIV  = 8,
   parameter int                          FSK_ZERO_DIV = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rate_sel,
   input  logic [1:0] code_sel,
   output logic       mod_out
);
   localparam int ADDR_W = $clog2(ID_ROWS * ID_COLS);
   localparam int CNT_W  = $clog2(SLOW_DIV);

   logic [CNT_W-1:0]  phase;
   logic [ADDR_W-1:0] addr;
   logic              at_start, at_mid, late_half, bit_end;
   logic              data_bit;
   line_code_e        code_e;

   assign code_e = line_code_e'(code_sel);

   cidt_bit_timer #(
      .FAST_DIV (FAST_DIV),
      .SLOW_DIV (SLOW_DIV),
      .ADDR_W   (ADDR_W),
      .CNT_W    (CNT_W)
   ) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .rate_sel  (rate_sel),
      .phase     (phase),
      .addr      (addr),
      .at_start  (at_start),
      .at_mid    (at_mid),
      .late_half (late_half),
      .bit_end   (bit_end)
   );

   cidt_id_rom #(
      .ROWS    (ID_ROWS),
      .COLS    (ID_COLS),
      .ADDR_W  (ADDR_W),
      .CONTENT (ID_PATTERN)
   ) u_rom (
      .addr  (addr),
      .bit_o (data_bit)
   );

   cidt_line_encoder #(
      .FSK_ONE_DIV  (FSK_ONE_DIV),
      .FSK_ZERO_DIV (FSK_ZERO_DIV)
   ) u_enc (
      .clk       (clk),
      .rst_n     (rst_n),
      .code      (code_e),
      .data_bit  (data_bit),
      .at_start  (at_start),
      .at_mid    (at_mid),
      .late_half (late_half),
      .bit_end   (bit_end),
      .mod_o     (mod_out)
   );
endmodule

// File: rtl/cidt_checker.sv
`timescale 1ns/1ps
module cidt_checker #(
   parameter int ADDR_W   = 7,
   parameter int CNT_W    = 6,
   parameter int FAST_DIV = 32,
   parameter int SLOW_DIV = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rate_sel,
   input logic [1:0]        code_sel,
   input logic              mod_out,
   input logic [ADDR_W-1:0] addr,
   input logic [CNT_W-1:0]  phase,
   input logic              at_start,
   input logic              at_mid,
   input logic              bit_end
);
   localparam logic [ADDR_W-1:0] ADDR_TOP = '1;
   localparam int               FAST_I   = FAST_DIV;
   localparam int               SLOW_I   = SLOW_DIV;

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_end |=> $stable(addr)); // R2

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_end && addr != ADDR_TOP) |=> (addr == $past(addr) + 1'b1)); // R2

   AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_end && addr == ADDR_TOP) |=> (addr == '0)); // R3

   AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(phase) < (rate_sel ? SLOW_I : FAST_I))); // R4

   AST_MANCH_MID: assert property (@(posedge clk) disable iff (!rst_n)
      (code_sel == 2'd0 && at_mid) |=> (mod_out != $past(mod_out))); // R5

   AST_BIPH_START: assert property (@(posedge clk) disable iff (!rst_n)
      (code_sel == 2'd1 && at_start) |=> (mod_out != $past(mod_out))); // R6

   AST_PSK_INBIT: assert property (@(posedge clk) disable iff (!rst_n)
      (code_sel == 2'd3 && !at_start) |=> (mod_out != $past(mod_out))); // R8
endmodule

bind cyclic_id_tx cidt_checker #(
   .ADDR_W   (ADDR_W),
   .CNT_W    (CNT_W),
   .FAST_DIV (FAST_DIV),
   .SLOW_DIV (SLOW_DIV)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rate_sel (rate_sel),
   .code_sel (code_sel),
   .mod_out  (mod_out),
   .addr     (addr),
   .phase    (phase),
   .at_start (at_start),
   .at_mid   (at_mid),
   .bit_end  (bit_end)
);

// File: tb/sim_cyclic_id_tx.sv
`timescale 1ns/1ps
module sim_cyclic_id_tx;
   localparam logic [127:0] ID = 128'h3E1D_94A7_0C5B_F268_D703_1A9E_6BC4_5F82;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rate_sel = 1'b0;
   logic [1:0] code_sel = 2'd0;
   logic       mod_out;

   int tests_run = 0;
   int tests_failed = 0;

   always #2 clk = ~clk;

   cyclic_id_tx #(.ID_PATTERN(ID)) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_sel (rate_sel),
      .code_sel (code_sel),
      .mod_out  (mod_out)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      tests_run++;
      if (!ok) begin
         tests_failed++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Hold reset, confirm idle output (R1), leave reset asserted at a negedge.
   task automatic hold_reset(input int code, input int rs);
      @(negedge clk);
      rst_n    = 1'b0;
      code_sel = 2'(code);
      rate_sel = rs[0];
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(mod_out === 1'b0, "R1", "output during reset", int'(mod_out), 0);
   endtask

   // Release reset and compare ncycles samples against the model.
   task automatic stream_check(input int code, input int rs, input int ncycles,
                               input string req, input bit with_wrap);
      int  per;
      bit  lvl;
      int  err1, err2, a1, e1, a2, e2, n1, n2;
      per = rs ? 64 : 32;
      lvl = 1'b0;
      err1 = 0; err2 = 0; a1 = 0; e1 = 0; a2 = 0; e2 = 0; n1 = 0; n2 = 0;
      rst_n = 1'b1;
      for (int n = 0; n < ncycles; n++) begin
         int ph;
         int dv;
         bit d, exp;
         ph = n % per;
         d  = ID[(n / per) % 128];
         case (code)
            0: exp = d ^ (ph >= per / 2);
            1: begin
               if (ph == 0) lvl = ~lvl;
               if (ph == per / 2 && !d) lvl = ~lvl;
               exp = lvl;
            end
            2: begin
               dv  = d ? 8 : 10;
               exp = ((ph % dv) < dv / 2);
            end
            default: exp = (n % 2 == 1) ^ d ^ ID[0];
         endcase
         @(negedge clk);
         if (mod_out !== exp) begin
            if (n < 128 * per) begin
               if (err1 == 0) begin a1 = int'(mod_out); e1 = int'(exp); n1 = n; end
               err1++;
            end else begin
               if (err2 == 0) begin a2 = int'(mod_out); e2 = int'(exp); n2 = n; end
               err2++;
            end
         end
      end
      check(err1 == 0, req, $sformatf("first pass code %0d rate %0d, pos %0d", code, rs, n1), a1, e1);
      if (with_wrap)
         check(err2 == 0, "R3", $sformatf("second pass code %0d, pos %0d", code, n2), a2, e2);
   endtask

   task automatic t_manch_fast();
      hold_reset(0, 0);
      stream_check(0, 0, 2 * 128 * 32, "R2 R5", 1'b1);
   endtask

   task automatic t_manch_slow();
      hold_reset(0, 1);
      stream_check(0, 1, 128 * 64, "R4 R5", 1'b0);
   endtask

   task automatic t_biph_fast();
      hold_reset(1, 0);
      stream_check(1, 0, 2 * 128 * 32, "R6", 1'b1);
   endtask

   task automatic t_biph_slow();
      hold_reset(1, 1);
      stream_check(1, 1, 128 * 64, "R4 R6", 1'b0);
   endtask

   task automatic t_fsk();
      hold_reset(2, 0);
      stream_check(2, 0, 128 * 32, "R7", 1'b0);
      hold_reset(2, 1);
      stream_check(2, 1, 128 * 64, "R4 R7", 1'b0);
   endtask

   task automatic t_psk();
      hold_reset(3, 0);
      stream_check(3, 0, 128 * 32, "R8", 1'b0);
      hold_reset(3, 1);
      stream_check(3, 1, 128 * 64, "R4 R8", 1'b0);
   endtask

   // R9: reset in the middle of a pass restarts at address 0
   task automatic t_midrun_reset();
      hold_reset(0, 0);
      rst_n = 1'b1;
      repeat (1501) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(mod_out === 1'b0, "R1", "output right after mid-run reset", int'(mod_out), 0);
      repeat (2) @(negedge clk);
      stream_check(0, 0, 400, "R9", 1'b0);
   endtask

   bit done = 1'b0;

   initial begin
      #700000;
      if (!done) begin
         check(1'b0, "R1", "watchdog expired", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
         $finish;
      end
   end

   initial begin
      t_manch_fast();
      t_manch_slow();
      t_biph_fast();
      t_biph_slow();
      t_fsk();
      t_psk();
      t_midrun_reset();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end
endmodule